// File: doc/BRIEF.md
# Prioritized Conversion Request Arbiter

This block sits in front of one shared converter and decides which of several channels it serves next. Each channel keeps a pending-request flag. Software or a hardware trigger sets the flag through a one-cycle set pulse. While the converter is idle, the block picks one pending channel and clears that channel's flag. It then sends the converter a one-cycle start pulse together with the channel number. The block marks the channel busy until the converter signals that the conversion is done. A conversion cannot be cut short.

The order among pending channels is a rotation. A small priority field names the channel that ranks first, and the remaining channels follow in ascending number, wrapping round. Software loads the priority field and a dynamic-mode enable through a simple write strobe. When dynamic mode is on and exactly one channel gate input is active, hardware copies that channel's number into the priority field. That channel then ranks first in the next arbitration.

Top module: `conv_req_arbiter`

## Requirements
- R1: After a synchronous active-low reset, all pending flags and busy bits are 0, the priority field is 0, dynamic mode is off, and no start pulse is issued.
- R2: A 1 on bit i of `req_set_i` at a clock edge sets pending flag i, and the flag shows on `req_pend_o` after that edge.
- R3: If the block is idle and at least one flag is pending at a clock edge, that same edge does all of the following: it clears the winner's flag, sets the winner's busy bit, and drives `conv_ch_o` to the winner. `conv_start_o` is then high for exactly one cycle.
- R4: A busy bit stays set, with no new start, until `conv_done_i` is sampled high. At most one busy bit is set at a time. Requests that arrive meanwhile stay pending and are arbitrated after completion.
- R5: Among pending channels, the channel equal to the priority field wins, and the others follow in ascending order modulo the channel count. With field 2 the order is 2, 3, 0, 1.
- R6: If a set pulse for a channel coincides with the edge at which that channel's flag is cleared for a start, the flag stays set.
- R7: With dynamic mode on and exactly one bit of `gate_i` high at an edge, the priority field takes that bit's index after the edge.
- R8: With no gate active, more than one gate active, or dynamic mode off, hardware leaves the priority field unchanged. A write strobe (`cfg_wr_i`) still loads `cfg_prio_i` and `cfg_dyn_en_i`.
- R9: If a write strobe and a dynamic update fall on the same edge, the priority field takes the dynamic value.
- R10: `conv_done_i` has no effect while no conversion is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_set_i | input | NUM_CH | Per-channel request set pulses |
| gate_i | input | NUM_CH | Per-channel gate levels for dynamic priority |
| cfg_wr_i | input | 1 | Write strobe for priority field and dynamic enable |
| cfg_prio_i | input | CH_W | Priority field value to write |
| cfg_dyn_en_i | input | 1 | Dynamic-mode enable value to write |
| conv_done_i | input | 1 | Converter completion pulse |
| conv_start_o | output | 1 | One-cycle start pulse to the converter |
| conv_ch_o | output | CH_W | Channel of the current or last conversion |
| busy_o | output | NUM_CH | Per-channel busy bits |
| req_pend_o | output | NUM_CH | Pending request flags |
| prio_o | output | CH_W | Current priority field |
| dyn_en_o | output | 1 | Current dynamic-mode enable |

## Verification
The bench builds the block with its default of four channels and a two-bit priority field. At that size every priority value can be written and every rotation exercised. The bench drains a full set of four simultaneous requests from each of the four starting points. It also runs dynamic updates from single-gate, multi-gate and no-gate patterns, and hits the coincidence cases of set-versus-clear and write-versus-update.

// File: rtl/cra_pkg.sv
// Package: shared types of the conversion request arbiter.
// Assumes: only the sequencer uses the state type.
package cra_pkg;

    // Sequencer states: waiting for work, or a conversion in flight.
    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_BUSY = 1'b1
    } seq_state_t;

endpackage : cra_pkg

// File: rtl/cra_req_flags.sv
// Module: cra_req_flags
// Holds one pending flag per channel. A set pulse wins over a clear in the same cycle.
// Assumes: clr_i has at most one bit high, driven by the sequencer at a launch.
module cra_req_flags #(
    parameter int NUM_CH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] set_i,
    input  logic [NUM_CH-1:0] clr_i,
    output logic [NUM_CH-1:0] pend_o
);

    logic [NUM_CH-1:0] pend_q;
    logic [NUM_CH-1:0] pend_d;

    // Next flag value: drop cleared bits, then apply sets on top.
    always_comb begin
        pend_d = (pend_q & ~clr_i) | set_i;
    end

    // Flag storage with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else begin
            pend_q <= pend_d;
        end
    end

    assign pend_o = pend_q;

endmodule : cra_req_flags

// File: rtl/cra_prio_reg.sv
// Module: cra_prio_reg
// Holds the priority field and the dynamic-mode enable. When the enable is set and
// exactly one gate is active, the field follows that gate. A software write loses
// to such an update in the same cycle.
// Assumes: gate_i is synchronous to clk.
module cra_prio_reg #(
    parameter int NUM_CH = 4,
    localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] gate_i,
    input  logic              wr_i,
    input  logic [CH_W-1:0]   wr_prio_i,
    input  logic              wr_dyn_i,
    output logic [CH_W-1:0]   prio_o,
    output logic              dyn_o
);

    logic [CH_W-1:0] prio_q;
    logic            dyn_q;
    logic            gate_single;
    logic [CH_W-1:0] gate_idx;
    logic            hw_upd;

    // Detect a gate vector with exactly one bit high.
    always_comb begin
        gate_single = (gate_i != '0) && ((gate_i & (gate_i - 1'b1)) == '0);
    end

    // Encode the position of the active gate (valid only when single).
    always_comb begin
        gate_idx = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (gate_i[i]) begin
                gate_idx = CH_W'(i);
            end
        end
    end

    // Hardware update applies only in dynamic mode with a lone gate.
    always_comb begin
        hw_upd = dyn_q && gate_single;
    end

    // Priority field: a hardware update beats a write, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prio_q <= '0;
        end else if (hw_upd) begin
            prio_q <= gate_idx;
        end else if (wr_i) begin
            prio_q <= wr_prio_i;
        end
    end

    // Dynamic enable changes only through the write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dyn_q <= 1'b0;
        end else if (wr_i) begin
            dyn_q <= wr_dyn_i;
        end
    end

    assign prio_o = prio_q;
    assign dyn_o  = dyn_q;

endmodule : cra_prio_reg

// File: rtl/cra_rot_picker.sv
// Module: cra_rot_picker
// Combinational rotating-priority selector. The channel equal to prio_i ranks first,
// then ascending numbers modulo NUM_CH.
// Assumes: prio_i < NUM_CH; the output is meaningless when valid_o is low.
module cra_rot_picker #(
    parameter int NUM_CH = 4,
    localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic [NUM_CH-1:0] req_i,
    input  logic [CH_W-1:0]   prio_i,
    output logic              valid_o,
    output logic [CH_W-1:0]   win_o
);

    // Any request present.
    always_comb begin
        valid_o = |req_i;
    end

    // Scan from lowest rank to highest so the highest-ranked request is kept last.
    always_comb begin
        win_o = prio_i;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (req_i[(int'(prio_i) + i) % NUM_CH]) begin
                win_o = CH_W'((int'(prio_i) + i) % NUM_CH);
            end
        end
    end

endmodule : cra_rot_picker

// File: rtl/cra_conv_seq.sv
// Module: cra_conv_seq
// Conversion sequencer. When idle with a valid grant, it launches the conversion:
// it clears the winner's flag, latches the channel, sets the busy bit and pulses
// start. The busy bit holds until the done pulse.
// Assumes: done_i is ignored while idle; no abort path exists.
module cra_conv_seq
    import cra_pkg::*;
#(
    parameter int NUM_CH = 4,
    localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              grant_valid_i,
    input  logic [CH_W-1:0]   grant_ch_i,
    input  logic              done_i,
    output logic [NUM_CH-1:0] clr_o,
    output logic              start_o,
    output logic [CH_W-1:0]   ch_o,
    output logic [NUM_CH-1:0] busy_o
);

    seq_state_t        state_q;
    logic              launch;
    logic [NUM_CH-1:0] grant_1h;
    logic              start_q;
    logic [CH_W-1:0]   ch_q;
    logic [NUM_CH-1:0] busy_q;

    // Launch a conversion when idle and something is pending.
    always_comb begin
        launch = (state_q == SEQ_IDLE) && grant_valid_i;
    end

    // One-hot form of the granted channel.
    always_comb begin
        grant_1h = '0;
        grant_1h[grant_ch_i] = 1'b1;
    end

    // Clear request goes only to the launched channel.
    always_comb begin
        clr_o = launch ? grant_1h : '0;
    end

    // State register: idle to busy on launch, back on done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
        end else begin
            case (state_q)
                SEQ_IDLE: if (launch) state_q <= SEQ_BUSY;
                SEQ_BUSY: if (done_i) state_q <= SEQ_IDLE;
                default:  state_q <= SEQ_IDLE;
            endcase
        end
    end

    // Start pulse lasts one cycle after each launch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= 1'b0;
        end else begin
            start_q <= launch;
        end
    end

    // Channel number captured at launch and held afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ch_q <= '0;
        end else if (launch) begin
            ch_q <= grant_ch_i;
        end
    end

    // Busy bits: set at launch, cleared at done while busy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= '0;
        end else if (launch) begin
            busy_q <= grant_1h;
        end else if ((state_q == SEQ_BUSY) && done_i) begin
            busy_q <= '0;
        end
    end

    assign start_o = start_q;
    assign ch_o    = ch_q;
    assign busy_o  = busy_q;

endmodule : cra_conv_seq

// File: rtl/conv_req_arbiter.sv
// Module: conv_req_arbiter (top)
// Arbitrates per-channel conversion requests onto one converter. It uses a rotating
// priority whose first channel is either written by software or taken from a lone
// active gate.
// Assumes: NUM_CH >= 2; all inputs are synchronous to clk.
module conv_req_arbiter #(
    parameter int NUM_CH = 4,
    localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] req_set_i,
    input  logic [NUM_CH-1:0] gate_i,
    input  logic              cfg_wr_i,
    input  logic [CH_W-1:0]   cfg_prio_i,
    input  logic              cfg_dyn_en_i,
    input  logic              conv_done_i,
    output logic              conv_start_o,
    output logic [CH_W-1:0]   conv_ch_o,
    output logic [NUM_CH-1:0] busy_o,
    output logic [NUM_CH-1:0] req_pend_o,
    output logic [CH_W-1:0]   prio_o,
    output logic              dyn_en_o
);

    logic [NUM_CH-1:0] pend;
    logic [NUM_CH-1:0] clr;
    logic [CH_W-1:0]   prio;
    logic              dyn_en;
    logic              grant_valid;
    logic [CH_W-1:0]   grant_ch;

    cra_req_flags #(.NUM_CH(NUM_CH)) u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (req_set_i),
        .clr_i  (clr),
        .pend_o (pend)
    );

    cra_prio_reg #(.NUM_CH(NUM_CH)) u_prio (
        .clk       (clk),
        .rst_n     (rst_n),
        .gate_i    (gate_i),
        .wr_i      (cfg_wr_i),
        .wr_prio_i (cfg_prio_i),
        .wr_dyn_i  (cfg_dyn_en_i),
        .prio_o    (prio),
        .dyn_o     (dyn_en)
    );

    cra_rot_picker #(.NUM_CH(NUM_CH)) u_pick (
        .req_i   (pend),
        .prio_i  (prio),
        .valid_o (grant_valid),
        .win_o   (grant_ch)
    );

    cra_conv_seq #(.NUM_CH(NUM_CH)) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .grant_valid_i (grant_valid),
        .grant_ch_i    (grant_ch),
        .done_i        (conv_done_i),
        .clr_o         (clr),
        .start_o       (conv_start_o),
        .ch_o          (conv_ch_o),
        .busy_o        (busy_o)
    );

    assign req_pend_o = pend;
    assign prio_o     = prio;
    assign dyn_en_o   = dyn_en;

endmodule : conv_req_arbiter

// File: rtl/cra_checker.sv
// Module: cra_checker
// Port-level properties of the arbiter, attached to every instance by bind.
// Assumes: the same NUM_CH as the bound instance.
module cra_checker #(
    parameter int NUM_CH = 4,
    localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NUM_CH-1:0] req_set_i,
    input logic [NUM_CH-1:0] gate_i,
    input logic              cfg_wr_i,
    input logic              conv_done_i,
    input logic              conv_start_o,
    input logic [CH_W-1:0]   conv_ch_o,
    input logic [NUM_CH-1:0] busy_o,
    input logic [NUM_CH-1:0] req_pend_o,
    input logic [CH_W-1:0]   prio_o,
    input logic              dyn_en_o
);

    // Index of the highest set gate bit.
    function automatic logic [CH_W-1:0] gate_pos(input logic [NUM_CH-1:0] g);
        logic [CH_W-1:0] p;
        p = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (g[i]) p = CH_W'(i);
        end
        return p;
    endfunction

    // R2
    set_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|req_set_i) |=> ((req_pend_o & $past(req_set_i)) == $past(req_set_i)));

    // R3
    start_marks_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start_o |-> (busy_o[conv_ch_o] && $onehot(busy_o)));

    // R3
    start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start_o |=> !conv_start_o);

    // R4
    busy_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(busy_o));

    // R4
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((|busy_o) && !conv_done_i) |=> $stable(busy_o));

    // R4
    no_start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|busy_o) |=> !conv_start_o);

    // R7
    dyn_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dyn_en_o && $onehot(gate_i)) |=> (prio_o == gate_pos($past(gate_i))));

    // R8
    prio_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_wr_i && !(dyn_en_o && $onehot(gate_i))) |=> $stable(prio_o));

    // R10
    idle_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o == '0 && req_pend_o == '0 && conv_done_i) |=> (busy_o == '0 && !conv_start_o));

endmodule : cra_checker

bind conv_req_arbiter cra_checker #(.NUM_CH(NUM_CH)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_set_i    (req_set_i),
    .gate_i       (gate_i),
    .cfg_wr_i     (cfg_wr_i),
    .conv_done_i  (conv_done_i),
    .conv_start_o (conv_start_o),
    .conv_ch_o    (conv_ch_o),
    .busy_o       (busy_o),
    .req_pend_o   (req_pend_o),
    .prio_o       (prio_o),
    .dyn_en_o     (dyn_en_o)
);

// File: tb/conv_req_arbiter_tb.sv
// Directed bench for conv_req_arbiter: one task per scenario, each checking its own results.
module conv_req_arbiter_tb;

    localparam int NUM_CH = 4;
    localparam int CH_W   = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NUM_CH-1:0] req_set_i = '0;
    logic [NUM_CH-1:0] gate_i = '0;
    logic              cfg_wr_i = 1'b0;
    logic [CH_W-1:0]   cfg_prio_i = '0;
    logic              cfg_dyn_en_i = 1'b0;
    logic              conv_done_i = 1'b0;
    logic              conv_start_o;
    logic [CH_W-1:0]   conv_ch_o;
    logic [NUM_CH-1:0] busy_o;
    logic [NUM_CH-1:0] req_pend_o;
    logic [CH_W-1:0]   prio_o;
    logic              dyn_en_o;

    int checks = 0;
    int errors = 0;
    bit done_all = 1'b0;

    always #2.5 clk = ~clk;

    conv_req_arbiter #(.NUM_CH(NUM_CH)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_set_i    (req_set_i),
        .gate_i       (gate_i),
        .cfg_wr_i     (cfg_wr_i),
        .cfg_prio_i   (cfg_prio_i),
        .cfg_dyn_en_i (cfg_dyn_en_i),
        .conv_done_i  (conv_done_i),
        .conv_start_o (conv_start_o),
        .conv_ch_o    (conv_ch_o),
        .busy_o       (busy_o),
        .req_pend_o   (req_pend_o),
        .prio_o       (prio_o),
        .dyn_en_o     (dyn_en_o)
    );

    // Advance one edge and settle away from it.
    task automatic cycle();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic cfg_write(input int p, input bit dyn);
        cfg_wr_i = 1'b1; cfg_prio_i = CH_W'(p); cfg_dyn_en_i = dyn;
        cycle();
        cfg_wr_i = 1'b0;
    endtask

    task automatic finish_conv();
        conv_done_i = 1'b1;
        cycle();
        conv_done_i = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1", "pending", int'(req_pend_o), 0);
        chk("R1", "busy", int'(busy_o), 0);
        chk("R1", "prio", int'(prio_o), 0);
        chk("R1", "dyn_en", int'(dyn_en_o), 0);
        chk("R1", "start", int'(conv_start_o), 0);
    endtask

    task automatic t_single_and_wait();
        req_set_i = 4'b0010;
        cycle();
        req_set_i = '0;
        chk("R2", "pending after set", int'(req_pend_o), 2);
        chk("R2", "no start yet", int'(conv_start_o), 0);
        cycle();
        chk("R3", "start pulse", int'(conv_start_o), 1);
        chk("R3", "channel", int'(conv_ch_o), 1);
        chk("R3", "busy bit", int'(busy_o), 2);
        chk("R3", "flag cleared", int'(req_pend_o), 0);
        cycle();
        chk("R3", "start one cycle", int'(conv_start_o), 0);
        req_set_i = 4'b0001;
        cycle();
        req_set_i = '0;
        chk("R4", "new request waits", int'(req_pend_o), 1);
        cycle();
        cycle();
        chk("R4", "busy held", int'(busy_o), 2);
        chk("R4", "no start while busy", int'(conv_start_o), 0);
        finish_conv();
        chk("R4", "busy cleared", int'(busy_o), 0);
        chk("R4", "still pending", int'(req_pend_o), 1);
        cycle();
        chk("R4", "waiting request starts", int'(conv_start_o), 1);
        chk("R4", "waiting channel", int'(conv_ch_o), 0);
        finish_conv();
    endtask

    task automatic t_rotation();
        for (int p = 0; p < NUM_CH; p++) begin
            cfg_write(p, 1'b0);
            chk("R8", "written prio", int'(prio_o), p);
            req_set_i = '1;
            cycle();
            req_set_i = '0;
            for (int k = 0; k < NUM_CH; k++) begin
                cycle();
                chk("R5", "start in order", int'(conv_start_o), 1);
                chk("R5", "rotation order", int'(conv_ch_o), (p + k) % NUM_CH);
                finish_conv();
            end
            chk("R5", "drained", int'(req_pend_o), 0);
        end
        cfg_write(0, 1'b0);
    endtask

    task automatic t_set_clear();
        req_set_i = 4'b0100;
        cycle();
        cycle();
        req_set_i = '0;
        chk("R6", "launch", int'(conv_ch_o), 2);
        chk("R6", "flag kept", int'(req_pend_o), 4);
        finish_conv();
        cycle();
        chk("R6", "second start", int'(conv_start_o), 1);
        chk("R6", "second channel", int'(conv_ch_o), 2);
        chk("R6", "flag now clear", int'(req_pend_o), 0);
        finish_conv();
    endtask

    task automatic t_dynamic();
        cfg_write(3, 1'b0);
        gate_i = 4'b0001;
        cycle();
        chk("R8", "disabled keeps prio", int'(prio_o), 3);
        gate_i = '0;
        cfg_write(0, 1'b1);
        chk("R8", "dyn enable written", int'(dyn_en_o), 1);
        gate_i = 4'b1000;
        cycle();
        chk("R7", "lone gate 3", int'(prio_o), 3);
        gate_i = '0;
        cycle();
        chk("R8", "no gate keeps", int'(prio_o), 3);
        gate_i = 4'b0110;
        cycle();
        chk("R8", "two gates keep", int'(prio_o), 3);
        cfg_write(1, 1'b1);
        chk("R8", "write with two gates", int'(prio_o), 1);
        gate_i = 4'b0100;
        cfg_write(0, 1'b1);
        chk("R9", "hardware beats write", int'(prio_o), 2);
        gate_i = 4'b0010;
        cycle();
        chk("R7", "lone gate 1", int'(prio_o), 1);
        req_set_i = '1;
        cycle();
        req_set_i = '0;
        for (int k = 0; k < NUM_CH; k++) begin
            cycle();
            chk("R7", "gate-chosen order", int'(conv_ch_o), (1 + k) % NUM_CH);
            finish_conv();
        end
        gate_i = '0;
        cfg_write(0, 1'b0);
    endtask

    task automatic t_done_idle();
        conv_done_i = 1'b1;
        cycle();
        conv_done_i = 1'b0;
        chk("R10", "idle done busy", int'(busy_o), 0);
        chk("R10", "idle done start", int'(conv_start_o), 0);
        req_set_i = 4'b1000;
        cycle();
        req_set_i = '0;
        cycle();
        chk("R10", "start after idle done", int'(conv_start_o), 1);
        chk("R10", "channel after idle done", int'(conv_ch_o), 3);
        cycle();
        chk("R10", "busy held", int'(busy_o), 8);
        finish_conv();
    endtask

    initial begin
        cycle();
        cycle();
        t_reset();
        rst_n = 1'b1;
        cycle();
        t_reset();
        t_single_and_wait();
        t_rotation();
        t_set_clear();
        t_dynamic();
        t_done_idle();
        done_all = 1'b1;
    end

    initial begin
        int n;
        n = 0;
        while (!done_all && n < 20000) begin
            @(posedge clk);
            n++;
        end
        if (!done_all) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        #1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule : conv_req_arbiter_tb